// File: doc/BRIEF.md
# Serial Controller Transmit/Receive FIFO Pair

This block holds the byte queues of a memory-mapped serial controller. A transmit queue is filled by software through a transmit buffer address and drained one byte at a time by the serialiser. A receive queue is filled by the deserialiser and drained by software through a receive buffer address. The bus decoder is reduced to a write strobe, a read strobe, a register index and 32-bit data.

Each queue has its own control word. The control word holds an enable, a flush command that clears itself one cycle after it is written, and a 6-bit service threshold. One read-only status word packs the receive fill, the transmit fill and the transmit free space. Software can therefore decide with a single read whether a byte may be written and whether the transmitter has drained. Two level outputs request service: one for a transmit queue that has run low, and one for a receive queue that has filled up.

Top module: `sio_fifo_pair`

## Requirements
- R1: After a synchronous active-low reset, both queues are disabled and empty, both thresholds are 0, both control words read 0, the status word reads 0x20000000 (32 free, default depth 32), and tx_req, rx_req and tx_valid are low.
- R2: Register index 0 is the transmit control word and index 1 is the receive control word. In each, bit 0 is the enable, bit 1 is the flush command and bits 13:8 are the threshold. A readback returns these fields at the same positions, and every other bit reads 0.
- R3: Both queues are first-in first-out. Bytes written to index 3 (bits 7:0) appear on tx_byte in write order. Bytes accepted on rx_put are returned in arrival order by reads of index 4, in bits 7:0.
- R4: The status word at index 2 carries the receive fill in bits 5:0, the transmit fill in bits 13:8 and the transmit free space (depth minus fill) in bits 29:24. All other bits are 0.
- R5: When the transmit queue holds depth entries, its free space reads 0 and further writes to index 3 are dropped. The stored contents and their order are unchanged.
- R6: A read of index 4 while the receive queue is empty returns 0 and leaves the fill unchanged.
- R7: Writing a control word with bit 1 set makes that bit read back 1 during the next cycle and 0 after it. The queue's fill is 0 from the cycle after that, and stored data is discarded.
- R8: One control write with bit 0 clear and bit 1 set both disables the queue and empties it.
- R9: While a queue is disabled, pushes and pops are ignored, reads of index 4 return 0, and the stored bytes are kept until it is enabled again.
- R10: tx_req is high exactly when the transmit queue is enabled and its fill is at or below its threshold.
- R11: rx_req is high exactly when the receive queue is enabled and its fill is at or above its threshold.
- R12: tx_valid is high exactly when the transmit queue is enabled and its fill is nonzero. tx_take pops the head byte.
- R13: A push and a pop in the same cycle on a queue that is neither empty nor full leave its fill unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; pops the receive queue at index 4 |
| bus_addr | input | 3 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| tx_valid | output | 1 | Transmit queue has a byte for the serialiser |
| tx_byte | output | 8 | Head byte of the transmit queue |
| tx_take | input | 1 | Serialiser consumes the head byte |
| rx_put | input | 1 | Deserialiser delivers a byte |
| rx_byte | input | 8 | Byte delivered by the deserialiser |
| tx_req | output | 1 | Transmit service request (level) |
| rx_req | output | 1 | Receive service request (level) |

## Verification
The assertions check the per-cycle invariants on every clock. These are the fill bound, a full queue that refuses a lone push, a flush that always empties on the following edge, a flush bit that falls unless rewritten, a frozen fill while disabled, zero data from an empty read, the sum of transmit fill and free space in the status word, and requests held low while disabled. Byte order, the exact threshold comparisons at and around each level, the register bit layout, and the retention of data across a disable are only shown by the bench's scenarios. The bench compares the outputs against values it derives from the requirements.

// File: rtl/sio_fifo_pkg.sv
// Package: shared constants and the register index type for the FIFO pair.
// Assumes every count field is 6 bits wide, so the depth must not exceed 63.
package sio_fifo_pkg;
    localparam int DATA_W        = 8;
    localparam int REG_W         = 32;
    localparam int FIELD_W       = 6;
    localparam int NUM_CH        = 2;
    localparam int CH_TX         = 0;
    localparam int CH_RX         = 1;
    localparam int CTL_EN_BIT    = 0;
    localparam int CTL_FLUSH_BIT = 1;
    localparam int CTL_LVL_LSB   = 8;
    localparam int ST_RXFILL_LSB = 0;
    localparam int ST_TXFILL_LSB = 8;
    localparam int ST_TXFREE_LSB = 24;

    typedef enum logic [2:0] {
        REG_TX_CTL = 3'd0,
        REG_RX_CTL = 3'd1,
        REG_STATUS = 3'd2,
        REG_TX_BUF = 3'd3,
        REG_RX_BUF = 3'd4
    } reg_sel_e;
endpackage

// File: rtl/sio_fifo_ctrl.sv
// Module: per-queue control word (enable, self-clearing flush, threshold).
// Assumes the write strobe is already qualified by the register index.
module sio_fifo_ctrl
    import sio_fifo_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [REG_W-1:0]   wdata,
    output logic               en,
    output logic               flush,
    output logic [FIELD_W-1:0] level,
    output logic [REG_W-1:0]   rdback
);
    logic               en_q;
    logic               flush_q;
    logic [FIELD_W-1:0] lvl_q;

    // Capture the fields on a write; flush is held for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            flush_q <= 1'b0;
            lvl_q   <= '0;
        end else begin
            flush_q <= wr && wdata[CTL_FLUSH_BIT];
            if (wr) begin
                en_q  <= wdata[CTL_EN_BIT];
                lvl_q <= wdata[CTL_LVL_LSB +: FIELD_W];
            end
        end
    end

    // Pack the fields back into their bit positions for readback.
    always_comb begin
        rdback                           = '0;
        rdback[CTL_EN_BIT]               = en_q;
        rdback[CTL_FLUSH_BIT]            = flush_q;
        rdback[CTL_LVL_LSB +: FIELD_W]   = lvl_q;
    end

    assign en    = en_q;
    assign flush = flush_q;
    assign level = lvl_q;

    AST_FLUSH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_q && !(wr && wdata[CTL_FLUSH_BIT])) |=> !flush_q); // R7
endmodule

// File: rtl/sio_fifo_store.sv
// Module: circular byte queue with fill count, enable gating and flush.
// Assumes the flush is a one-cycle pulse; flush overrides push and pop.
module sio_fifo_store
    import sio_fifo_pkg::*;
#(
    parameter int DEPTH = 32
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               flush,
    input  logic               push,
    input  logic [DATA_W-1:0]  push_data,
    input  logic               pop,
    output logic [DATA_W-1:0]  head,
    output logic [FIELD_W-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0]   LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [FIELD_W-1:0] FULL_CNT = FIELD_W'(DEPTH);

    logic [DATA_W-1:0]  mem [DEPTH];
    logic [PTR_W-1:0]   wr_ptr;
    logic [PTR_W-1:0]   rd_ptr;
    logic [FIELD_W-1:0] cnt_q;
    logic               push_ok;
    logic               pop_ok;

    // Qualify push and pop with enable, flush and fill limits.
    always_comb begin
        push_ok = en && !flush && push && (cnt_q != FULL_CNT);
        pop_ok  = en && !flush && pop  && (cnt_q != '0);
    end

    // Store the accepted byte at the write pointer.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Advance the pointers and the fill count, or clear them on flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            end
            case ({push_ok, pop_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign head  = mem[rd_ptr];
    assign count = cnt_q;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_CNT); // R5
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == FULL_CNT && push && !pop && !flush) |=> cnt_q == FULL_CNT); // R5
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> cnt_q == '0); // R7
    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !flush) |=> $stable(cnt_q)); // R9
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && pop && !push && !flush) |=> cnt_q == '0); // R6
    AST_PUSH_POP_BAL: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !flush && push && pop && cnt_q != '0 && cnt_q != FULL_CNT)
        |=> $stable(cnt_q)); // R13
endmodule

// File: rtl/sio_status_pack.sv
// Module: packs the receive fill, transmit fill and transmit free space.
// Assumes both counts are already bounded by the depth.
module sio_status_pack
    import sio_fifo_pkg::*;
#(
    parameter int DEPTH = 32
)(
    input  logic [FIELD_W-1:0] rx_fill,
    input  logic [FIELD_W-1:0] tx_fill,
    output logic [REG_W-1:0]   status
);
    logic [FIELD_W-1:0] tx_free;

    // Derive the free space and place each field at its bit position.
    always_comb begin
        tx_free                             = FIELD_W'(DEPTH) - tx_fill;
        status                              = '0;
        status[ST_RXFILL_LSB +: FIELD_W]    = rx_fill;
        status[ST_TXFILL_LSB +: FIELD_W]    = tx_fill;
        status[ST_TXFREE_LSB +: FIELD_W]    = tx_free;
    end
endmodule

// File: rtl/sio_fifo_pair.sv
// Module: top of the serial FIFO pair - register decode, queues, requests.
// Assumes single-cycle strobes; read data is combinational on the index.
module sio_fifo_pair
    import sio_fifo_pkg::*;
#(
    parameter int DEPTH = 32
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [2:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    input  logic              tx_take,
    input  logic              rx_put,
    input  logic [7:0]        rx_byte,
    output logic              tx_req,
    output logic              rx_req
);
    logic               ch_en    [NUM_CH];
    logic               ch_flush [NUM_CH];
    logic [FIELD_W-1:0] ch_lvl   [NUM_CH];
    logic [REG_W-1:0]   ch_rd    [NUM_CH];
    logic               ch_push  [NUM_CH];
    logic [DATA_W-1:0]  ch_pdata [NUM_CH];
    logic               ch_pop   [NUM_CH];
    logic [DATA_W-1:0]  ch_head  [NUM_CH];
    logic [FIELD_W-1:0] ch_cnt   [NUM_CH];
    logic [REG_W-1:0]   status;
    reg_sel_e           sel;

    assign sel = reg_sel_e'(bus_addr);

    // One control word and one queue per direction.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        sio_fifo_ctrl u_ctrl (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr     (bus_wr && (bus_addr == 3'(c))),
            .wdata  (bus_wdata),
            .en     (ch_en[c]),
            .flush  (ch_flush[c]),
            .level  (ch_lvl[c]),
            .rdback (ch_rd[c])
        );
        sio_fifo_store #(.DEPTH(DEPTH)) u_store (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (ch_en[c]),
            .flush     (ch_flush[c]),
            .push      (ch_push[c]),
            .push_data (ch_pdata[c]),
            .pop       (ch_pop[c]),
            .head      (ch_head[c]),
            .count     (ch_cnt[c])
        );
    end

    // Route bus and line traffic to the push and pop sides of each queue.
    always_comb begin
        ch_push[CH_TX]  = bus_wr && (sel == REG_TX_BUF);
        ch_pdata[CH_TX] = bus_wdata[DATA_W-1:0];
        ch_pop[CH_TX]   = tx_take;
        ch_push[CH_RX]  = rx_put;
        ch_pdata[CH_RX] = rx_byte;
        ch_pop[CH_RX]   = bus_rd && (sel == REG_RX_BUF);
    end

    sio_status_pack #(.DEPTH(DEPTH)) u_status (
        .rx_fill (ch_cnt[CH_RX]),
        .tx_fill (ch_cnt[CH_TX]),
        .status  (status)
    );

    // Select the read data for the addressed register.
    always_comb begin
        bus_rdata = '0;
        case (sel)
            REG_TX_CTL: bus_rdata = ch_rd[CH_TX];
            REG_RX_CTL: bus_rdata = ch_rd[CH_RX];
            REG_STATUS: bus_rdata = status;
            REG_RX_BUF: if (ch_en[CH_RX] && ch_cnt[CH_RX] != '0)
                            bus_rdata = {{(REG_W-DATA_W){1'b0}}, ch_head[CH_RX]};
            default:    bus_rdata = '0;
        endcase
    end

    // Line side of the transmit queue and the two service requests.
    always_comb begin
        tx_valid = ch_en[CH_TX] && (ch_cnt[CH_TX] != '0);
        tx_byte  = ch_head[CH_TX];
        tx_req   = ch_en[CH_TX] && (ch_cnt[CH_TX] <= ch_lvl[CH_TX]);
        rx_req   = ch_en[CH_RX] && (ch_cnt[CH_RX] >= ch_lvl[CH_RX]);
    end

    AST_TX_REQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_en[CH_TX] |-> !tx_req); // R10
    AST_RX_REQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_en[CH_RX] |-> !rx_req); // R11
    AST_EMPTY_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel == REG_RX_BUF && ch_cnt[CH_RX] == '0) |-> bus_rdata == '0); // R6
    AST_STAT_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (7'(status[ST_TXFILL_LSB +: FIELD_W]) + 7'(status[ST_TXFREE_LSB +: FIELD_W]))
        == 7'(DEPTH)); // R4
    AST_TX_VALID_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (status[ST_TXFILL_LSB +: FIELD_W] == '0) |-> !tx_valid); // R12
endmodule

// File: tb/tb_sio_fifo_pair.sv
module tb_sio_fifo_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_valid, tx_take = 1'b0, rx_put = 1'b0, tx_req, rx_req;
    logic [7:0]  tx_byte, rx_byte = '0;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    localparam logic [2:0] A_TXC = 3'd0, A_RXC = 3'd1, A_ST = 3'd2, A_TXB = 3'd3, A_RXB = 3'd4;

    // Stimulus: {threshold, fill}; expected: {tx_req, rx_req}
    localparam logic [13:0] VEC [8] = '{
        {6'd0,  6'd0,  1'b1, 1'b1},
        {6'd4,  6'd3,  1'b1, 1'b0},
        {6'd4,  6'd4,  1'b1, 1'b1},
        {6'd4,  6'd5,  1'b0, 1'b1},
        {6'd16, 6'd15, 1'b1, 1'b0},
        {6'd16, 6'd17, 1'b0, 1'b1},
        {6'd31, 6'd32, 1'b0, 1'b1},
        {6'd40, 6'd32, 1'b1, 1'b0}
    };

    sio_fifo_pair dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_take(tx_take),
        .rx_put(rx_put), .rx_byte(rx_byte), .tx_req(tx_req), .rx_req(rx_req)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] st(input int rxf, input int txf);
        return 32'(rxf) | (32'(txf) << 8) | (32'(32 - txf) << 24);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        tick();
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic line_in(input logic [7:0] b);
        rx_put = 1'b1; rx_byte = b;
        tick();
        rx_put = 1'b0;
    endtask

    task automatic take();
        tx_take = 1'b1;
        tick();
        tx_take = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int errs;
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        peek(A_ST, d);  check("R1 status", d, 32'h2000_0000);
        peek(A_TXC, d); check("R1 tx ctl", d, 32'h0);
        peek(A_RXC, d); check("R1 rx ctl", d, 32'h0);
        check("R1 outputs", {29'd0, tx_req, rx_req, tx_valid}, 32'h0);

        // R10 R11 R4: threshold table walked by one loop
        for (int i = 0; i < 8; i++) begin
            logic [5:0] lvl, fill;
            lvl = VEC[i][13:8]; fill = VEC[i][7:2];
            wr(A_TXC, 32'h3 | (32'(lvl) << 8));
            wr(A_RXC, 32'h3 | (32'(lvl) << 8));
            tick();
            for (int k = 0; k < int'(fill); k++) begin
                bus_wr = 1'b1; bus_addr = A_TXB; bus_wdata = 32'(k + i);
                rx_put = 1'b1; rx_byte = 8'(k);
                tick();
                bus_wr = 1'b0; rx_put = 1'b0;
            end
            check($sformatf("R10 tx_req row %0d", i), {31'd0, tx_req}, {31'd0, VEC[i][1]});
            check($sformatf("R11 rx_req row %0d", i), {31'd0, rx_req}, {31'd0, VEC[i][0]});
            peek(A_ST, d);
            check($sformatf("R4 status row %0d", i), d, st(int'(fill), int'(fill)));
        end

        // R2 control readback
        wr(A_TXC, 32'h0000_2A01);
        peek(A_TXC, d); check("R2 tx ctl readback", d, 32'h0000_2A01);
        wr(A_RXC, 32'hFFFF_3D01);
        peek(A_RXC, d); check("R2 rx ctl other bits zero", d, 32'h0000_3D01);

        // R7 flush of transmit queue holding 5 bytes
        wr(A_TXC, 32'h3); tick();
        wr(A_RXC, 32'h3); tick();
        for (int k = 0; k < 5; k++) wr(A_TXB, 32'(k));
        peek(A_ST, d); check("R7 pre-flush fill", d, st(0, 5));
        wr(A_TXC, 32'h3);
        peek(A_TXC, d); check("R7 flush bit high", d, 32'h3);
        tick();
        peek(A_TXC, d); check("R7 flush bit cleared", d, 32'h1);
        peek(A_ST, d);  check("R7 emptied", d, st(0, 0));

        // R3 R12 transmit order
        wr(A_TXB, 32'hA1); wr(A_TXB, 32'hB2); wr(A_TXB, 32'hC3);
        check("R12 tx_valid set", {31'd0, tx_valid}, 32'h1);
        check("R3 tx head 1", {24'd0, tx_byte}, 32'hA1); take();
        check("R3 tx head 2", {24'd0, tx_byte}, 32'hB2); take();
        check("R3 tx head 3", {24'd0, tx_byte}, 32'hC3); take();
        check("R12 tx_valid clear when empty", {31'd0, tx_valid}, 32'h0);

        // R3 receive order, R6 empty read
        line_in(8'h11); line_in(8'h22); line_in(8'h33);
        rd(A_RXB, d); check("R3 rx read 1", d, 32'h11);
        rd(A_RXB, d); check("R3 rx read 2", d, 32'h22);
        rd(A_RXB, d); check("R3 rx read 3", d, 32'h33);
        rd(A_RXB, d); check("R6 empty read zero", d, 32'h0);
        peek(A_ST, d); check("R6 fill unchanged", d, st(0, 0));

        // R13 simultaneous push and pop
        wr(A_TXB, 32'h5); wr(A_TXB, 32'h6);
        bus_wr = 1'b1; bus_addr = A_TXB; bus_wdata = 32'h7; tx_take = 1'b1;
        tick();
        bus_wr = 1'b0; tx_take = 1'b0;
        peek(A_ST, d); check("R13 fill unchanged", d, st(0, 2));
        check("R13 head advanced", {24'd0, tx_byte}, 32'h6);
        wr(A_TXC, 32'h3); tick();

        // R5 full transmit queue drops the extra write
        for (int k = 0; k < 33; k++) wr(A_TXB, 32'(k + 64));
        peek(A_ST, d); check("R5 full free zero", d, st(0, 32));
        errs = 0;
        for (int k = 0; k < 32; k++) begin
            if (tx_byte !== 8'(k + 64)) errs++;
            take();
        end
        check("R5 stored order intact", 32'(errs), 32'h0);
        check("R5 extra write dropped", {31'd0, tx_valid}, 32'h0);

        // R9 disabled receive queue keeps data and ignores traffic
        line_in(8'h5A); line_in(8'h6B);
        wr(A_RXC, 32'h0);
        line_in(8'h7C);
        rd(A_RXB, d); check("R9 disabled read zero", d, 32'h0);
        peek(A_ST, d); check("R9 fill frozen", d, st(2, 0));
        check("R11 rx_req low disabled", {31'd0, rx_req}, 32'h0);
        wr(A_TXB, 32'h99);
        wr(A_RXC, 32'h1);
        rd(A_RXB, d); check("R9 data kept", d, 32'h5A);

        // R8 shutdown in one write per queue
        wr(A_TXB, 32'h1); wr(A_TXB, 32'h2);
        wr(A_TXC, 32'h2); wr(A_RXC, 32'h2); tick();
        peek(A_ST, d); check("R8 both empty", d, st(0, 0));
        peek(A_TXC, d); check("R8 tx disabled", d, 32'h0);
        check("R8 requests low", {30'd0, tx_req, rx_req}, 32'h0);
        wr(A_TXB, 32'h3);
        peek(A_ST, d); check("R9 disabled push ignored", d, st(0, 0));

        done = 1'b1;
        summary();
        $finish;
    end
endmodule